// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block sits beside a processor core and turns its wait-for-interrupt (WFI) and wait-for-event (WFE) strobes into a low-power mode. At the strobe it takes a snapshot of the configuration bits and picks one of three modes. Light sleep gates only the CPU clock. Clock-stop halts every system clock and can also put the regulator into low-power operation. Power-down asks the power controller to remove the core domain.

Deep entries are refused outright while any pending flag is set. They are held back while flash programming or a peripheral bus transfer is still in flight. A light-sleep request made with the on-exit option waits for the return from the last interrupt handler before the clock is gated. Wake-up is selective. An entry made through WFI resumes only on an acknowledged interrupt, and an entry made through WFE resumes only on an event. When the block leaves clock-stop it raises a one-cycle request to switch the system clock to the internal RC oscillator. If the regulator was in low-power operation, the block then keeps the CPU clock gated for a programmable number of cycles while the regulator recovers.

Top module: `lpm_sequencer`

## Requirements
- R1: After synchronous reset the outputs are cpu_clk_en=1, sys_clk_stop=0, reg_lp_en=0, standby_req=0, hsi_sel=0.
- R2: A wait_req with cfg_deep=0 gates the CPU clock (cpu_clk_en=0, sys_clk_stop=0) from the cycle after the strobe. The only exception is a WFI with cfg_on_exit=1. wait_is_event=1 marks a WFE and 0 marks a WFI.
- R3: A WFI with cfg_deep=0 and cfg_on_exit=1 leaves the CPU clock running until isr_exit is sampled high. The clock is gated from the cycle after that.
- R4: An entry made through WFI wakes only on irq_ack, and an entry made through WFE wakes only on evt_wake. The wrong source has no effect. After wake from light sleep, or from clock-stop without a delay, cpu_clk_en returns to 1 in the cycle after the wake is sampled.
- R5: A wait_req with cfg_deep=1, cfg_pdds=0 and no pending flag reaches clock-stop. Clock-stop means sys_clk_stop=1, cpu_clk_en=0 and reg_lp_en equal to the cfg_lpreg value captured at the strobe. If nothing is busy, this is two cycles after the strobe.
- R6: A deep entry does not reach clock-stop or power-down in any cycle that follows a cycle in which flash_busy or bus_busy was high. The CPU clock keeps running meanwhile.
- R7: A wait_req with cfg_deep=1 and any bit of pend_flags set is ignored. The outputs stay at the run values.
- R8: A deep entry with cfg_pdds=1 gives standby_req=1, sys_clk_stop=1 and cpu_clk_en=0. These values hold until reset, whatever the wake inputs or strobes do.
- R9: hsi_sel is high for exactly one cycle, the first cycle after clock-stop is left.
- R10: On wake from clock-stop with the captured cfg_lpreg=1 and reg_delay=D>0, the outputs are cpu_clk_en=0, sys_clk_stop=0 and reg_lp_en=0 for D cycles, then the run values. With D=0 there is no delay cycle.
- R11: Changes to cfg_deep or cfg_lpreg while the core is in clock-stop have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_req | input | 1 | WFI/WFE strobe from the core |
| wait_is_event | input | 1 | 1 = strobe is WFE, 0 = WFI |
| cfg_deep | input | 1 | Select deep (clock-stop or power-down) entry |
| cfg_on_exit | input | 1 | Light sleep on handler return |
| cfg_pdds | input | 1 | Deep entry powers the core domain down |
| cfg_lpreg | input | 1 | Regulator low-power during clock-stop |
| isr_exit | input | 1 | Return from the lowest-priority handler |
| pend_flags | input | PEND_W | Pending flag summary (lines, peripherals, alarm) |
| flash_busy | input | 1 | Flash programming in progress |
| bus_busy | input | 1 | Peripheral bus access in progress |
| irq_ack | input | 1 | Acknowledged interrupt wake |
| evt_wake | input | 1 | Event wake |
| reg_delay | input | DLY_W | Regulator recovery cycles |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_stop | output | 1 | Stop all system clocks |
| reg_lp_en | output | 1 | Regulator low-power enable |
| standby_req | output | 1 | Power-down request |
| hsi_sel | output | 1 | Pulse: switch system clock to internal RC |

## Verification
A corrupted state register shows up at the ports within one cycle, because every output is registered straight from the next state. A gated CPU clock with no matching entry is the most likely sign. A wrongly latched mode or wake source shows up later. The wrong wake input releases the core, or the right one fails to, in the cycle after that input is driven. A bad delay counter moves the return of cpu_clk_en away from exactly D cycles after the wake.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_ENTER_WAIT = 3'd1,
    ST_SLEEP      = 3'd2,
    ST_STOP       = 3'd3,
    ST_STOP_DLY   = 3'd4,
    ST_STANDBY    = 3'd5
  } lpm_state_e;

  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'd0,
    MODE_STOP    = 2'd1,
    MODE_STANDBY = 2'd2
  } lpm_mode_e;
endpackage

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
  import lpm_pkg::*;
#(
  parameter int PEND_W = 3
) (
  input  logic              wait_is_event,
  input  logic              cfg_deep,
  input  logic              cfg_on_exit,
  input  logic              cfg_pdds,
  input  logic [PEND_W-1:0] pend_flags,
  output lpm_mode_e         mode,
  output logic              hold_for_exit,
  output logic              pend_block
);
  always_comb begin
    if (!cfg_deep)     mode = MODE_SLEEP;
    else if (cfg_pdds) mode = MODE_STANDBY;
    else               mode = MODE_STOP;
  end

  // handler-return entry applies to WFI light sleep only
  assign hold_for_exit = !cfg_deep && cfg_on_exit && !wait_is_event;
  assign pend_block    = cfg_deep && (|pend_flags);
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             run,
  output logic             last
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == DLY_W'(1));
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int PEND_W = 3,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wait_req,
  input  logic              wait_is_event,
  input  logic              cfg_deep,
  input  logic              cfg_on_exit,
  input  logic              cfg_pdds,
  input  logic              cfg_lpreg,
  input  logic              isr_exit,
  input  logic [PEND_W-1:0] pend_flags,
  input  logic              flash_busy,
  input  logic              bus_busy,
  input  logic              irq_ack,
  input  logic              evt_wake,
  input  logic [DLY_W-1:0]  reg_delay,
  output logic              cpu_clk_en,
  output logic              sys_clk_stop,
  output logic              reg_lp_en,
  output logic              standby_req,
  output logic              hsi_sel
);
  lpm_state_e state_q, state_d;
  lpm_mode_e  mode_d, mode_q;
  logic       hold_for_exit, pend_block;
  logic       evt_q, lp_q;
  logic       wake_hit, tmr_last, tmr_load, accept;

  lpm_mode_decode #(.PEND_W(PEND_W)) u_dec (
    .wait_is_event (wait_is_event),
    .cfg_deep      (cfg_deep),
    .cfg_on_exit   (cfg_on_exit),
    .cfg_pdds      (cfg_pdds),
    .pend_flags    (pend_flags),
    .mode          (mode_d),
    .hold_for_exit (hold_for_exit),
    .pend_block    (pend_block)
  );

  lpm_wake_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (reg_delay),
    .run      (state_q == ST_STOP_DLY),
    .last     (tmr_last)
  );

  assign accept   = (state_q == ST_RUN) && wait_req && !pend_block;
  assign wake_hit = evt_q ? evt_wake : irq_ack;
  assign tmr_load = (state_q == ST_STOP) && (state_d == ST_STOP_DLY);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: if (accept) begin
        if (mode_d == MODE_SLEEP && !hold_for_exit) state_d = ST_SLEEP;
        else                                         state_d = ST_ENTER_WAIT;
      end
      ST_ENTER_WAIT: begin
        if (mode_q == MODE_SLEEP) begin
          if (isr_exit) state_d = ST_SLEEP;
        end else if (!flash_busy && !bus_busy) begin
          state_d = (mode_q == MODE_STANDBY) ? ST_STANDBY : ST_STOP;
        end
      end
      ST_SLEEP: if (wake_hit) state_d = ST_RUN;
      ST_STOP: if (wake_hit)
        state_d = (lp_q && reg_delay != '0) ? ST_STOP_DLY : ST_RUN;
      ST_STOP_DLY: if (tmr_last) state_d = ST_RUN;
      ST_STANDBY: state_d = ST_STANDBY;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_RUN;
      mode_q       <= MODE_SLEEP;
      evt_q        <= 1'b0;
      lp_q         <= 1'b0;
      cpu_clk_en   <= 1'b1;
      sys_clk_stop <= 1'b0;
      reg_lp_en    <= 1'b0;
      standby_req  <= 1'b0;
      hsi_sel      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_q <= mode_d;
        evt_q  <= wait_is_event;
        lp_q   <= cfg_lpreg;
      end
      cpu_clk_en   <= (state_d == ST_RUN) || (state_d == ST_ENTER_WAIT);
      sys_clk_stop <= (state_d == ST_STOP) || (state_d == ST_STANDBY);
      reg_lp_en    <= (state_d == ST_STOP) && lp_q;
      standby_req  <= (state_d == ST_STANDBY);
      hsi_sel      <= (state_q == ST_STOP) && (state_d != ST_STOP);
    end
  end
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic flash_busy,
  input logic bus_busy,
  input logic cpu_clk_en,
  input logic sys_clk_stop,
  input logic reg_lp_en,
  input logic standby_req,
  input logic hsi_sel
);
  // R5
  stop_gates_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    sys_clk_stop |-> !cpu_clk_en);

  // R5
  lpreg_only_in_stop_chk: assert property (@(posedge clk) disable iff (rst)
    reg_lp_en |-> sys_clk_stop);

  // R6
  busy_holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    (!sys_clk_stop && (flash_busy || bus_busy)) |=> !sys_clk_stop);

  // R8
  standby_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    standby_req |=> (standby_req && sys_clk_stop));

  // R9
  hsi_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    hsi_sel |=> !hsi_sel);

  // R9
  hsi_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hsi_sel) |-> $past(sys_clk_stop));
endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .flash_busy   (flash_busy),
  .bus_busy     (bus_busy),
  .cpu_clk_en   (cpu_clk_en),
  .sys_clk_stop (sys_clk_stop),
  .reg_lp_en    (reg_lp_en),
  .standby_req  (standby_req),
  .hsi_sel      (hsi_sel)
);

// File: tb/lpm_sequencer_tb.sv
module lpm_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PEND_W = 3;
  localparam int DLY_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wait_req = 0, wait_is_event = 0, cfg_deep = 0, cfg_on_exit = 0;
  logic cfg_pdds = 0, cfg_lpreg = 0, isr_exit = 0;
  logic [PEND_W-1:0] pend_flags = '0;
  logic flash_busy = 0, bus_busy = 0, irq_ack = 0, evt_wake = 0;
  logic [DLY_W-1:0] reg_delay = 8'd3;
  logic cpu_clk_en, sys_clk_stop, reg_lp_en, standby_req, hsi_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_sequencer #(.PEND_W(PEND_W), .DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst(rst), .wait_req(wait_req), .wait_is_event(wait_is_event),
    .cfg_deep(cfg_deep), .cfg_on_exit(cfg_on_exit), .cfg_pdds(cfg_pdds),
    .cfg_lpreg(cfg_lpreg), .isr_exit(isr_exit), .pend_flags(pend_flags),
    .flash_busy(flash_busy), .bus_busy(bus_busy), .irq_ack(irq_ack),
    .evt_wake(evt_wake), .reg_delay(reg_delay), .cpu_clk_en(cpu_clk_en),
    .sys_clk_stop(sys_clk_stop), .reg_lp_en(reg_lp_en),
    .standby_req(standby_req), .hsi_sel(hsi_sel)
  );

  typedef struct {
    bit         chk;
    logic [4:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // expected vector order: {cpu_clk_en, sys_clk_stop, reg_lp_en, standby_req, hsi_sel}
  task automatic cyc(input bit chk, input logic [4:0] exp, input string tag);
    item_t it;
    it.chk = chk; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compares one queued item per clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it  = exp_q.pop_front();
      act = {cpu_clk_en, sys_clk_stop, reg_lp_en, standby_req, hsi_sel};
      if (it.chk) begin
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: outputs actual=%b expected=%b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(0, '0, "");
    cyc(0, '0, "");
    rst = 0;
    cyc(1, 5'b10000, "R1");

    // light sleep, WFI: wrong source ignored
    wait_req = 1; cyc(1, 5'b00000, "R2");
    wait_req = 0; cyc(1, 5'b00000, "R2");
    evt_wake = 1; cyc(1, 5'b00000, "R4");
    evt_wake = 0; irq_ack = 1; cyc(1, 5'b10000, "R4");
    irq_ack = 0; cyc(1, 5'b10000, "R4");

    // light sleep, WFE
    wait_req = 1; wait_is_event = 1; cyc(1, 5'b00000, "R2");
    wait_req = 0; wait_is_event = 0; irq_ack = 1; cyc(1, 5'b00000, "R4");
    irq_ack = 0; evt_wake = 1; cyc(1, 5'b10000, "R4");
    evt_wake = 0;

    // sleep on handler return
    cfg_on_exit = 1; wait_req = 1; cyc(1, 5'b10000, "R3");
    wait_req = 0; cyc(1, 5'b10000, "R3");
    isr_exit = 1; cyc(1, 5'b00000, "R3");
    isr_exit = 0; cfg_on_exit = 0; irq_ack = 1; cyc(1, 5'b10000, "R3");
    irq_ack = 0;

    // pending flag blocks deep entry
    cfg_deep = 1; pend_flags = 3'b100; wait_req = 1; cyc(1, 5'b10000, "R7");
    wait_req = 0; cyc(1, 5'b10000, "R7");
    cyc(1, 5'b10000, "R7");
    pend_flags = '0;

    // clock-stop held off by busy
    flash_busy = 1; wait_req = 1; cyc(1, 5'b10000, "R6");
    wait_req = 0; cyc(1, 5'b10000, "R6");
    cyc(1, 5'b10000, "R6");
    flash_busy = 0; bus_busy = 1; cyc(1, 5'b10000, "R6");
    bus_busy = 0; cyc(1, 5'b01000, "R5");
    cfg_lpreg = 1; cfg_deep = 0; cyc(1, 5'b01000, "R11");
    evt_wake = 1; cyc(1, 5'b01000, "R4");
    evt_wake = 0; irq_ack = 1; cyc(1, 5'b10001, "R9");
    irq_ack = 0; cyc(1, 5'b10000, "R9");

    // clock-stop with low-power regulator, WFE, delay 3
    cfg_deep = 1; wait_is_event = 1; wait_req = 1; cyc(1, 5'b10000, "R5");
    wait_req = 0; wait_is_event = 0; cyc(1, 5'b01100, "R5");
    evt_wake = 1; cyc(1, 5'b00001, "R10");
    evt_wake = 0; cyc(1, 5'b00000, "R10");
    cyc(1, 5'b00000, "R10");
    cyc(1, 5'b10000, "R10");

    // delay of zero
    reg_delay = '0; wait_req = 1; cyc(1, 5'b10000, "R5");
    wait_req = 0; cyc(1, 5'b01100, "R5");
    irq_ack = 1; cyc(1, 5'b10001, "R10");
    irq_ack = 0; cyc(1, 5'b10000, "R10");

    // power-down
    cfg_pdds = 1; wait_req = 1; cyc(1, 5'b10000, "R8");
    wait_req = 0; cyc(1, 5'b01010, "R8");
    irq_ack = 1; evt_wake = 1; cyc(1, 5'b01010, "R8");
    wait_req = 1; cyc(1, 5'b01010, "R8");
    wait_req = 0; irq_ack = 0; evt_wake = 0; cyc(1, 5'b01010, "R8");

    cyc(0, '0, "");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule